// File: doc/BRIEF.md
# Branch-Record Address Read Access Arbiter

This block decides, within a single combinational step, what happens to a privileged read of one of the branch-record address registers. It looks at the current exception level, the halted-debug state, the secure-debug-disable flag, and an implementation choice for trap priority while halted. It also takes the top-level secure control field for branch records, the non-secure state bit, the fine-grain-trap enable bit, and the hypervisor fine-grain read-enable bit. From these it produces exactly one of four outcomes: permit the read, treat it as undefined, trap to level 2, or trap to level 3.

The outcome is a one-hot vector. A trap of either kind also drives a fixed 6-bit syndrome class. The block holds no state. The surrounding core uses the outcome to choose between returning register data and taking an exception. Exception entry and the register storage are outside this block.

Top module: `brb_rd_arbiter`

## Requirements
- R1: `outcome` is always one-hot. Bit 0 is permit, bit 1 is undefined, bit 2 is trap to level 2, and bit 3 is trap to level 3.
- R2: Any read from level 0 (`cur_el` = 0) gives undefined.
- R3: Any read from level 3 (`cur_el` = 3) is permitted.
- R4: At levels 1 and 2, the read is undefined with top priority when all of these hold: `dbg_halted`, `has_el3`, `sec_dbg_dis`, `halt_l3_prio`, and a level-3 block condition. The block condition is met in either of two cases:
  - secure state (`nonsec` = 0) with `top_ctl` not equal to 2'b11;
  - non-secure state with `top_ctl[0]` = 0.
- R5: At level 1 only, when R4 does not apply, a trap to level 2 is taken if both of these hold:
  - `el2_enabled` is set;
  - either `has_el3` is set and `fgt_en` = 0, or `hyp_rd_en` = 0.
- R6: A level-2 read never traps to level 2, whatever `el2_enabled`, `fgt_en` and `hyp_rd_en` are.
- R7: At levels 1 and 2, when neither R4 nor R5 applies, the level-3 block condition with `has_el3` set gives a trap to level 3. If `dbg_halted` and `sec_dbg_dis` are both set, it gives undefined instead.
- R8: When `has_el3` = 0, no read traps to level 3 and no read is undefined at levels 1 and 2 through R4 or R7.
- R9: `syn_class` is 6'h18 whenever a trap is signalled. Otherwise it is zero.
- R10: At levels 1 and 2, a read that meets none of the conditions in R4, R5 and R7 is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_el | input | 2 | Current exception level of the requester |
| dbg_halted | input | 1 | Core is in halted debug state |
| sec_dbg_dis | input | 1 | Secure debug disabled |
| halt_l3_prio | input | 1 | Implementation choice: level-3 undefined takes priority while halted |
| has_el3 | input | 1 | Level 3 is implemented |
| el2_enabled | input | 1 | Level 2 is enabled in the current state |
| top_ctl | input | 2 | Top-level secure branch-record access control field |
| nonsec | input | 1 | Non-secure state |
| fgt_en | input | 1 | Fine-grain traps enabled from level 3 |
| hyp_rd_en | input | 1 | Hypervisor fine-grain read enable (0 traps) |
| outcome | output | 4 | One-hot result: permit, undefined, trap L2, trap L3 |
| syn_class | output | 6 | Syndrome class, valid with a trap, else zero |

## Verification
A wrong priority between the halted-undefined check, the level-2 trap and the level-3 trap shows up at once as the wrong bit of `outcome` for a particular input combination. Because the block is purely combinational, every fault appears in the same cycle as the stimulus. The bench therefore walks the whole input space of 4096 combinations. It compares both outputs against a behavioural model on every clock, so a rule that fires for only one sparse corner still gets a direct check.

// File: rtl/brb_rd_pkg.sv
package brb_rd_pkg;
  localparam int unsigned EL_W   = 2;
  localparam int unsigned CTL_W  = 2;
  localparam int unsigned SYN_W  = 6;
  localparam int unsigned RES_W  = 4;
  localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

  typedef enum logic [EL_W-1:0] {
    LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3
  } lvl_e;

  // one-hot bit positions of the outcome vector
  localparam int unsigned RES_PERMIT = 0;
  localparam int unsigned RES_UNDEF  = 1;
  localparam int unsigned RES_TRAP2  = 2;
  localparam int unsigned RES_TRAP3  = 3;

  // secure top-level control blocks the access
  function automatic logic top_blocks(input logic ns, input logic [CTL_W-1:0] ctl);
    if (ns) return ~ctl[0];
    return ctl != {CTL_W{1'b1}};
  endfunction
endpackage

// File: rtl/brb_l3_gate.sv
module brb_l3_gate
  import brb_rd_pkg::*;
(
  input  logic             has_el3,
  input  logic             nonsec,
  input  logic [CTL_W-1:0] top_ctl,
  input  logic             dbg_halted,
  input  logic             sec_dbg_dis,
  input  logic             halt_l3_prio,
  output logic             l3_block,
  output logic             halt_sdd,
  output logic             early_undef
);
  always_comb begin
    l3_block    = has_el3 & top_blocks(nonsec, top_ctl);
    halt_sdd    = dbg_halted & sec_dbg_dis;
    early_undef = halt_sdd & halt_l3_prio & l3_block;
  end

  always_comb begin
    // R8
    no_el3_block_chk: assert (has_el3 || !l3_block);
    // R4
    early_needs_block_chk: assert (!early_undef || (l3_block && dbg_halted));
  end
endmodule

// File: rtl/brb_l2_gate.sv
module brb_l2_gate
  import brb_rd_pkg::*;
(
  input  logic [EL_W-1:0] cur_el,
  input  logic            el2_enabled,
  input  logic            has_el3,
  input  logic            fgt_en,
  input  logic            hyp_rd_en,
  output logic            l2_trap
);
  logic fgt_cond;
  always_comb begin
    fgt_cond = (has_el3 & ~fgt_en) | ~hyp_rd_en;
    l2_trap  = (cur_el == LVL1) & el2_enabled & fgt_cond;
  end

  always_comb begin
    // R6
    l2_only_from_l1_chk: assert (!l2_trap || cur_el == LVL1);
  end
endmodule

// File: rtl/brb_rd_arbiter.sv
module brb_rd_arbiter
  import brb_rd_pkg::*;
(
  input  logic [1:0] cur_el,
  input  logic       dbg_halted,
  input  logic       sec_dbg_dis,
  input  logic       halt_l3_prio,
  input  logic       has_el3,
  input  logic       el2_enabled,
  input  logic [1:0] top_ctl,
  input  logic       nonsec,
  input  logic       fgt_en,
  input  logic       hyp_rd_en,
  output logic [3:0] outcome,
  output logic [5:0] syn_class
);
  logic l3_block, halt_sdd, early_undef, l2_trap;
  logic trap_any;

  brb_l3_gate u_l3 (
    .has_el3     (has_el3),
    .nonsec      (nonsec),
    .top_ctl     (top_ctl),
    .dbg_halted  (dbg_halted),
    .sec_dbg_dis (sec_dbg_dis),
    .halt_l3_prio(halt_l3_prio),
    .l3_block    (l3_block),
    .halt_sdd    (halt_sdd),
    .early_undef (early_undef)
  );

  brb_l2_gate u_l2 (
    .cur_el     (cur_el),
    .el2_enabled(el2_enabled),
    .has_el3    (has_el3),
    .fgt_en     (fgt_en),
    .hyp_rd_en  (hyp_rd_en),
    .l2_trap    (l2_trap)
  );

  always_comb begin
    outcome = '0;
    unique case (lvl_e'(cur_el))
      LVL0: outcome[RES_UNDEF]  = 1'b1;
      LVL3: outcome[RES_PERMIT] = 1'b1;
      default: begin
        if (early_undef)   outcome[RES_UNDEF] = 1'b1;
        else if (l2_trap)  outcome[RES_TRAP2] = 1'b1;
        else if (l3_block) begin
          if (halt_sdd)    outcome[RES_UNDEF] = 1'b1;
          else             outcome[RES_TRAP3] = 1'b1;
        end
        else               outcome[RES_PERMIT] = 1'b1;
      end
    endcase
    trap_any  = outcome[RES_TRAP2] | outcome[RES_TRAP3];
    syn_class = trap_any ? SYN_SYSREG : '0;
  end

  always_comb begin
    // R1
    onehot_res_chk: assert ($onehot(outcome));
    // R2
    lvl0_undef_chk: assert (cur_el != LVL0 || outcome[RES_UNDEF]);
    // R3
    lvl3_permit_chk: assert (cur_el != LVL3 || outcome[RES_PERMIT]);
    // R8
    no_el3_no_trap3_chk: assert (has_el3 || !outcome[RES_TRAP3]);
    // R9
    syn_valid_chk: assert ((syn_class != '0) == (outcome[RES_TRAP2] || outcome[RES_TRAP3]));
  end
endmodule

// File: tb/brb_rd_arbiter_bench.sv
module brb_rd_arbiter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] cur_el = '0;
  logic dbg_halted = 0, sec_dbg_dis = 0, halt_l3_prio = 0, has_el3 = 0;
  logic el2_enabled = 0, nonsec = 0, fgt_en = 0, hyp_rd_en = 0;
  logic [1:0] top_ctl = '0;
  logic [3:0] outcome;
  logic [5:0] syn_class;

  int checks = 0, fails = 0;

  brb_rd_arbiter u_brb_rd_arbiter (
    .cur_el(cur_el), .dbg_halted(dbg_halted), .sec_dbg_dis(sec_dbg_dis),
    .halt_l3_prio(halt_l3_prio), .has_el3(has_el3), .el2_enabled(el2_enabled),
    .top_ctl(top_ctl), .nonsec(nonsec), .fgt_en(fgt_en), .hyp_rd_en(hyp_rd_en),
    .outcome(outcome), .syn_class(syn_class)
  );

  // behavioural reference: returns result code 0 permit,1 undef,2 trap2,3 trap3
  function automatic int ref_model(input int el, input bit h, input bit s, input bit p,
                                   input bit e3, input bit e2, input int ctl,
                                   input bit ns, input bit fg, input bit hr,
                                   output string req);
    bit blocked;
    if (el == 0) begin req = "R2"; return 1; end
    if (el == 3) begin req = "R3"; return 0; end
    if (!e3) blocked = 0;
    else if (ns) blocked = (ctl % 2 == 0);
    else blocked = (ctl != 3);
    if (h && s && p && blocked) begin req = "R4"; return 1; end
    if (el == 1 && e2 && ((e3 && !fg) || !hr)) begin req = "R5"; return 2; end
    if (blocked) begin req = "R7"; return (h && s) ? 1 : 3; end
    req = (el == 2 && e2) ? "R6" : "R10";
    return 0;
  endfunction

  task automatic check(input string req, input logic [3:0] exp_o, input logic [5:0] exp_s);
    checks++;
    if (outcome !== exp_o || syn_class !== exp_s) begin
      fails++;
      $display("FAIL %s: outcome=%b syn=%h expected outcome=%b syn=%h (vec el=%0d)",
               req, outcome, syn_class, exp_o, exp_s, cur_el);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    string req;
    int code;
    logic [3:0] eo;
    logic [5:0] es;
    @(negedge clk);
    // reset-like all-zero state: level 0 -> undefined (R2)
    @(posedge clk);
    check("R2", 4'b0010, 6'h00);
    for (int v = 0; v < 4096; v++) begin
      @(negedge clk);
      {cur_el, dbg_halted, sec_dbg_dis, halt_l3_prio, has_el3, el2_enabled,
       top_ctl, nonsec, fgt_en, hyp_rd_en} = v[11:0];
      code = ref_model(int'(cur_el), dbg_halted, sec_dbg_dis, halt_l3_prio,
                       has_el3, el2_enabled, int'(top_ctl), nonsec, fgt_en,
                       hyp_rd_en, req);
      eo = 4'b0001 << code;
      es = (code >= 2) ? 6'h18 : 6'h00;  // R9
      if (!has_el3 && code == 3) req = "R8";
      @(posedge clk);
      #1;
      check(req, eo, es);  // R1 one-hot compared as whole vector
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule